// File: doc/BRIEF.md
# Two-Level Hysteresis Backpressure Controller

This block generates the pause signals for a buffered multi-stage cell switch. There are two buffering levels. The first is a set of central queues, each fed by several input ports. The second is a group of downstream crosspoint buffers behind each central queue, one per output. The block sees only enqueue and dequeue events. It keeps an occupancy count for every queue and buffer, and from each count it raises or clears a pause flag. A flag rises when the count exceeds an upper threshold and clears when the count falls to a lower threshold or below. Between the two thresholds the flag keeps its previous value.

A central queue's own pause travels to its source ports over a feedback path of `CQ_DLY` cycles. A crosspoint buffer's pause first reaches the central queue that feeds it, after `XB_DLY` cycles. That central queue must then stop sending to the buffer. The central queue also passes the pause on to its source ports for that output, which takes another `CQ_DLY` cycles. Cells already queued centrally may keep draining into a paused buffer. The buffer therefore keeps counting arrivals until it is full. Each threshold must leave enough space for the cells that can still arrive during its feedback delay.

Top module: `fc_twolevel_flowctl`

## Requirements
- R1: A central queue's occupancy rises by one per enqueue and falls by one per dequeue. An enqueue and a dequeue in the same cycle leave it unchanged.
- R2: Occupancy never exceeds its depth and never goes below zero. An enqueue into a full queue and a dequeue from an empty queue are ignored. This applies to central queues and crosspoint buffers alike.
- R3: A central queue's pause flag sets when its occupancy becomes greater than `CQ_PAUSE` (default 10 of 16).
- R4: A central queue's pause flag clears when its occupancy is at most `CQ_RESUME` (default 4). For any occupancy in between, the flag holds its previous value.
- R5: `src_cq_pause[i]` changes exactly `CQ_DLY` clock edges (default 2) after the edge that registers the threshold-crossing event.
- R6: Crosspoint buffers count and apply hysteresis the same way. They pause above `XB_PAUSE` (default 5 of 8) and resume at or below `XB_RESUME` (default 2).
- R7: `cq_xb_hold[j]` is the flag of buffer j as seen by its central queue. It changes `XB_DLY` edges (default 1) after the buffer's crossing event.
- R8: `src_dest_pause[j]` passes buffer j's pause on to the source ports. It changes `XB_DLY + CQ_DLY` edges after the buffer's crossing event.
- R9: A paused crosspoint buffer still counts enqueues (cells draining from its central queue) up to its depth.
- R10: Channels are independent. Buffer j is index `q*NUM_OUT + o` for central queue q and output o. Events on one queue or buffer never change another channel's flags.
- R11: An active-low reset clears every count, flag and delay stage, so all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cq_enq | input | NUM_CQ | Cell enqueued into central queue i |
| cq_deq | input | NUM_CQ | Cell dequeued from central queue i |
| xb_enq | input | NUM_CQ*NUM_OUT | Cell written into crosspoint buffer j |
| xb_deq | input | NUM_CQ*NUM_OUT | Cell read from crosspoint buffer j |
| cq_xb_hold | output | NUM_CQ*NUM_OUT | Central queue must not send to buffer j |
| src_dest_pause | output | NUM_CQ*NUM_OUT | Sources pause cells for the output behind buffer j |
| src_cq_pause | output | NUM_CQ | Sources pause all sending to central queue i |

## Verification
The checker assumes each enqueue or dequeue input is a single event per cycle. It also assumes reset is asserted for at least one edge before traffic starts. Its occupancy and threshold properties then hold even for overflow or underflow attempts, because the counters clamp. The stimulus changes inputs only on falling edges and holds each event for exactly one rising edge. It deliberately pushes past full and pops below empty, so that clamping is exercised inside those assumptions. After each burst it waits longer than the combined feedback delay before sampling.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_UP   = 2'd1,
        OCC_DOWN = 2'd2
    } occ_ev_e;

    // Net effect of one cycle's events on a clamped counter.
    function automatic occ_ev_e occ_event(input logic inc, input logic dec,
                                          input logic at_full, input logic at_empty);
        if (inc && !dec && !at_full)       return OCC_UP;
        else if (dec && !inc && !at_empty) return OCC_DOWN;
        else                               return OCC_HOLD;
    endfunction

endpackage

// File: rtl/fc_occ_tracker.sv
module fc_occ_tracker
    import fc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PAUSE_AT  = 10,
    parameter int RESUME_AT = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] occ,
    output logic          paused
);

    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
    localparam logic [CW-1:0] PAUSE_C  = CW'(PAUSE_AT);
    localparam logic [CW-1:0] RESUME_C = CW'(RESUME_AT);

    typedef struct packed {
        logic [CW-1:0] occ;
        logic          paused;
    } trk_state_t;

    trk_state_t st_d, st_q;
    occ_ev_e    ev;

    always_comb begin
        st_d = st_q;
        ev   = occ_event(inc, dec, st_q.occ == DEPTH_C, st_q.occ == '0);
        case (ev)
            OCC_UP:   st_d.occ = st_q.occ + CW'(1);
            OCC_DOWN: st_d.occ = st_q.occ - CW'(1);
            default:  st_d.occ = st_q.occ;
        endcase
        // Hysteresis evaluated on the next count so flag and count move together.
        if (st_d.occ > PAUSE_C)
            st_d.paused = 1'b1;
        else if (st_d.occ <= RESUME_C)
            st_d.paused = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ    = st_q.occ;
    assign paused = st_q.paused;

endmodule

// File: rtl/fc_delay_line.sv
module fc_delay_line #(
    parameter int W   = 4,
    parameter int DLY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DLY == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [DLY-1:0][W-1:0] stg_d, stg_q;

            always_comb begin
                stg_d[0] = din;
                for (int i = 1; i < DLY; i++) stg_d[i] = stg_q[i-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= stg_d;
            end

            assign dout = stg_q[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/fc_twolevel_flowctl.sv
module fc_twolevel_flowctl #(
    parameter int NUM_CQ    = 2,
    parameter int NUM_OUT   = 2,
    parameter int CQ_DEPTH  = 16,
    parameter int CQ_PAUSE  = 10,
    parameter int CQ_RESUME = 4,
    parameter int CQ_DLY    = 2,
    parameter int XB_DEPTH  = 8,
    parameter int XB_PAUSE  = 5,
    parameter int XB_RESUME = 2,
    parameter int XB_DLY    = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CQ-1:0]         cq_enq,
    input  logic [NUM_CQ-1:0]         cq_deq,
    input  logic [NUM_CQ*NUM_OUT-1:0] xb_enq,
    input  logic [NUM_CQ*NUM_OUT-1:0] xb_deq,
    output logic [NUM_CQ*NUM_OUT-1:0] cq_xb_hold,
    output logic [NUM_CQ*NUM_OUT-1:0] src_dest_pause,
    output logic [NUM_CQ-1:0]         src_cq_pause
);

    localparam int NUM_XB = NUM_CQ * NUM_OUT;
    localparam int CQ_CW  = $clog2(CQ_DEPTH + 1);
    localparam int XB_CW  = $clog2(XB_DEPTH + 1);

    logic [NUM_CQ-1:0][CQ_CW-1:0] cq_occ;
    logic [NUM_XB-1:0][XB_CW-1:0] xb_occ;
    logic [NUM_CQ-1:0]            cq_flag;
    logic [NUM_XB-1:0]            xb_flag;

    // Level 1: central queues
    for (genvar g = 0; g < NUM_CQ; g++) begin : g_cq
        fc_occ_tracker #(
            .DEPTH(CQ_DEPTH), .PAUSE_AT(CQ_PAUSE), .RESUME_AT(CQ_RESUME)
        ) u_trk (
            .clk(clk), .rst_n(rst_n),
            .inc(cq_enq[g]), .dec(cq_deq[g]),
            .occ(cq_occ[g]), .paused(cq_flag[g])
        );
    end

    // Level 2: crosspoint buffers, index q*NUM_OUT+o
    for (genvar g = 0; g < NUM_XB; g++) begin : g_xb
        fc_occ_tracker #(
            .DEPTH(XB_DEPTH), .PAUSE_AT(XB_PAUSE), .RESUME_AT(XB_RESUME)
        ) u_trk (
            .clk(clk), .rst_n(rst_n),
            .inc(xb_enq[g]), .dec(xb_deq[g]),
            .occ(xb_occ[g]), .paused(xb_flag[g])
        );
    end

    // Central-queue pause to sources
    fc_delay_line #(.W(NUM_CQ), .DLY(CQ_DLY)) u_dl_cq (
        .clk(clk), .rst_n(rst_n), .din(cq_flag), .dout(src_cq_pause)
    );

    // Buffer pause to its feeding central queue
    fc_delay_line #(.W(NUM_XB), .DLY(XB_DLY)) u_dl_xb (
        .clk(clk), .rst_n(rst_n), .din(xb_flag), .dout(cq_xb_hold)
    );

    // Central queue passes the per-output pause on to its sources
    fc_delay_line #(.W(NUM_XB), .DLY(CQ_DLY)) u_dl_relay (
        .clk(clk), .rst_n(rst_n), .din(cq_xb_hold), .dout(src_dest_pause)
    );

endmodule

// File: rtl/fc_flow_checker.sv
module fc_flow_checker #(
    parameter int NUM_CQ    = 2,
    parameter int NUM_XB    = 4,
    parameter int CQ_DEPTH  = 16,
    parameter int CQ_PAUSE  = 10,
    parameter int CQ_RESUME = 4,
    parameter int XB_DEPTH  = 8,
    parameter int XB_PAUSE  = 5,
    parameter int XB_RESUME = 2,
    localparam int CQ_CW    = $clog2(CQ_DEPTH + 1),
    localparam int XB_CW    = $clog2(XB_DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CQ-1:0][CQ_CW-1:0] cq_occ,
    input logic [NUM_CQ-1:0]            cq_flag,
    input logic [NUM_CQ-1:0]            cq_enq,
    input logic [NUM_CQ-1:0]            cq_deq,
    input logic [NUM_XB-1:0][XB_CW-1:0] xb_occ,
    input logic [NUM_XB-1:0]            xb_flag
);

    for (genvar g = 0; g < NUM_CQ; g++) begin : g_cq_chk
        assert_cq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cq_occ[g]) <= CQ_DEPTH);
        assert_cq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cq_occ[g]) > CQ_PAUSE |-> cq_flag[g]);
        assert_cq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            int'(cq_occ[g]) <= CQ_RESUME |-> !cq_flag[g]);
        assert_cq_balanced_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (cq_enq[g] && cq_deq[g]) |=> $stable(cq_occ[g]));
        assert_cq_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!cq_enq[g] && !cq_deq[g]) |=> $stable(cq_occ[g]));
    end

    for (genvar g = 0; g < NUM_XB; g++) begin : g_xb_chk
        assert_xb_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            int'(xb_occ[g]) <= XB_DEPTH);
        assert_xb_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(xb_occ[g]) > XB_PAUSE |-> xb_flag[g]);
        assert_xb_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            int'(xb_occ[g]) <= XB_RESUME |-> !xb_flag[g]);
    end

endmodule

bind fc_twolevel_flowctl fc_flow_checker #(
    .NUM_CQ(NUM_CQ), .NUM_XB(NUM_CQ*NUM_OUT),
    .CQ_DEPTH(CQ_DEPTH), .CQ_PAUSE(CQ_PAUSE), .CQ_RESUME(CQ_RESUME),
    .XB_DEPTH(XB_DEPTH), .XB_PAUSE(XB_PAUSE), .XB_RESUME(XB_RESUME)
) u_flow_chk (
    .clk(clk), .rst_n(rst_n),
    .cq_occ(cq_occ), .cq_flag(cq_flag), .cq_enq(cq_enq), .cq_deq(cq_deq),
    .xb_occ(xb_occ), .xb_flag(xb_flag)
);

// File: tb/tb_fc_twolevel_flowctl.sv
module tb_fc_twolevel_flowctl;

    localparam int NCQ = 2;
    localparam int NXB = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCQ-1:0] cq_enq = '0, cq_deq = '0;
    logic [NXB-1:0] xb_enq = '0, xb_deq = '0;
    logic [NXB-1:0] cq_xb_hold, src_dest_pause;
    logic [NCQ-1:0] src_cq_pause;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    fc_twolevel_flowctl dut (
        .clk(clk), .rst_n(rst_n),
        .cq_enq(cq_enq), .cq_deq(cq_deq),
        .xb_enq(xb_enq), .xb_deq(xb_deq),
        .cq_xb_hold(cq_xb_hold), .src_dest_pause(src_dest_pause),
        .src_cq_pause(src_cq_pause)
    );

    // Step: {target(1=buffer), op(1 enq,2 deq,3 both), count, expected flag}
    localparam int NSTEP = 21;
    localparam logic [11:0] STEPS [NSTEP] = '{
        {1'b0, 2'd1, 8'd10, 1'b0}, {1'b0, 2'd1, 8'd1,  1'b1},
        {1'b0, 2'd2, 8'd6,  1'b1}, {1'b0, 2'd2, 8'd1,  1'b0},
        {1'b0, 2'd1, 8'd6,  1'b0}, {1'b0, 2'd3, 8'd5,  1'b0},
        {1'b0, 2'd1, 8'd1,  1'b1}, {1'b0, 2'd1, 8'd20, 1'b1},
        {1'b0, 2'd2, 8'd12, 1'b0}, {1'b0, 2'd2, 8'd10, 1'b0},
        {1'b0, 2'd1, 8'd11, 1'b1}, {1'b0, 2'd2, 8'd7,  1'b0},
        {1'b1, 2'd1, 8'd5,  1'b0}, {1'b1, 2'd1, 8'd1,  1'b1},
        {1'b1, 2'd2, 8'd3,  1'b1}, {1'b1, 2'd2, 8'd1,  1'b0},
        {1'b1, 2'd1, 8'd10, 1'b1}, {1'b1, 2'd2, 8'd6,  1'b0},
        {1'b1, 2'd2, 8'd5,  1'b0}, {1'b1, 2'd1, 8'd6,  1'b1},
        {1'b1, 2'd2, 8'd4,  1'b0}
    };

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Apply n single-edge events; returns at the falling edge after the last one.
    task automatic do_op(input bit tgt, input int idx, input logic [1:0] op, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tgt) begin xb_enq[idx] = op[0]; xb_deq[idx] = op[1]; end
            else     begin cq_enq[idx] = op[0]; cq_deq[idx] = op[1]; end
            @(posedge clk);
        end
        @(negedge clk);
        cq_enq = '0; cq_deq = '0; xb_enq = '0; xb_deq = '0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 reset src_cq_pause", int'(src_cq_pause), 0);
        check("R11 reset cq_xb_hold", int'(cq_xb_hold), 0);
        check("R11 reset src_dest_pause", int'(src_dest_pause), 0);
        rst_n = 1'b1;

        // Table walk: central queue 0 (R1 R2 R3 R4), then buffer 0 (R2 R6 R7 R8), isolation R10
        for (int s = 0; s < NSTEP; s++) begin
            logic [11:0] e;
            e = STEPS[s];
            do_op(e[11], 0, e[10:9], int'(e[8:1]));
            settle();
            if (!e[11]) begin
                check($sformatf("R1 R2 R3 R4 step %0d src_cq_pause[0]", s),
                      int'(src_cq_pause[0]), int'(e[0]));
                check($sformatf("R10 step %0d other flags", s),
                      int'({src_cq_pause[1], cq_xb_hold, src_dest_pause}), 0);
            end else begin
                check($sformatf("R6 R7 step %0d cq_xb_hold[0]", s),
                      int'(cq_xb_hold[0]), int'(e[0]));
                check($sformatf("R2 R8 step %0d src_dest_pause[0]", s),
                      int'(src_dest_pause[0]), int'(e[0]));
                check($sformatf("R10 step %0d other flags", s),
                      int'({src_cq_pause, cq_xb_hold[3:1], src_dest_pause[3:1]}), 0);
            end
        end

        // R5: latency of central-queue pause on queue 1
        do_op(1'b0, 1, 2'd1, 10);
        settle();
        do_op(1'b0, 1, 2'd1, 1);           // crossing registered at edge k
        check("R5 k+0 src_cq_pause[1]", int'(src_cq_pause[1]), 0);
        @(posedge clk); @(negedge clk);
        check("R5 k+1 src_cq_pause[1]", int'(src_cq_pause[1]), 0);
        @(posedge clk); @(negedge clk);
        check("R5 k+2 src_cq_pause[1]", int'(src_cq_pause[1]), 1);

        // R7 R8: latency of buffer pause on buffer 2 (queue 1, output 0)
        do_op(1'b1, 2, 2'd1, 5);
        settle();
        do_op(1'b1, 2, 2'd1, 1);
        check("R7 k+0 cq_xb_hold[2]", int'(cq_xb_hold[2]), 0);
        @(posedge clk); @(negedge clk);
        check("R7 k+1 cq_xb_hold[2]", int'(cq_xb_hold[2]), 1);
        check("R8 k+1 src_dest_pause[2]", int'(src_dest_pause[2]), 0);
        @(posedge clk); @(negedge clk);
        check("R8 k+2 src_dest_pause[2]", int'(src_dest_pause[2]), 0);
        @(posedge clk); @(negedge clk);
        check("R8 k+3 src_dest_pause[2]", int'(src_dest_pause[2]), 1);

        // R9: paused buffer still counts drained cells: 6 -> 8, then 4 leaves 4 (still paused)
        do_op(1'b1, 2, 2'd1, 2);
        do_op(1'b1, 2, 2'd2, 4);
        settle();
        check("R9 cq_xb_hold[2] after drain while paused", int'(cq_xb_hold[2]), 1);
        do_op(1'b1, 2, 2'd2, 2);
        settle();
        check("R9 cq_xb_hold[2] resumed at 2", int'(cq_xb_hold[2]), 0);

        // R11: reset while paused clears everything
        do_op(1'b1, 3, 2'd1, 6);
        settle();
        check("R11 pre-reset cq_xb_hold[3]", int'(cq_xb_hold[3]), 1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11 mid-run reset src_cq_pause", int'(src_cq_pause), 0);
        check("R11 mid-run reset cq_xb_hold", int'(cq_xb_hold), 0);
        check("R11 mid-run reset src_dest_pause", int'(src_dest_pause), 0);
        rst_n = 1'b1;
        do_op(1'b1, 3, 2'd1, 5);           // counting restarts from zero
        settle();
        check("R11 R6 buffer 3 at 5 after reset", int'(cq_xb_hold[3]), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule